// File: doc/BRIEF.md
# Pluggable Module Control and Alarm Pin Controller

This block handles the slow control and status pins of a hot-pluggable optical module adapter. On the host side it samples a transmitter-off request, a low-power request, an active-low module reset, a transceiver-IC reset, a three-bit management port address and a two-bit power interlock code. It drives back a power-up-complete flag, a ready flag, a fault flag, a receive loss-of-signal flag and an active-low global alarm. Toward the downstream module it drives transmitter-off, low-power and active-low reset lines. Every asynchronous input passes through a two-flop synchroniser. No input is used before it has been synchronised.

A small sequencer governs power-up. When the synchronised module reset is released and low power is not requested, the sequencer checks the interlock budget against the module's own power need. If the budget is too small, it enters a fault state. Otherwise it waits a parameterised number of cycles, raises power-complete, and raises ready one cycle later. A low-power request or a module reset returns the sequencer to its idle state on the next clock edge.

Top module: `modpin_ctrl`

## Requirements
- R1: Each asynchronous input reaches its use through two flops. A change driven before clock edge E is visible at `port_addr_o`, `los_o` and at the alarm-bit part of `glb_alarm_n_o` after edge E+1.
- R2: After synchronous reset, and while `rst` is high, the outputs have these values: `pwr_done_o`=0, `ready_o`=0, `fault_o`=0, `los_o`=0, `glb_alarm_n_o`=1, `down_txoff_o`=1, `down_lowpwr_o`=1, `down_rst_n_o`=0.
- R3: Suppose `host_rst_n_i`=1 and `host_lowpwr_i`=0 are driven before edge E, with an adequate budget. Then `pwr_done_o` rises after edge E+2+PWRUP_CYC and not before.
- R4: `ready_o` rises exactly one cycle after `pwr_done_o`, and `ready_o` never stands high without `pwr_done_o`.
- R5: Driving `host_lowpwr_i`=1 or `host_rst_n_i`=0 before edge E clears `pwr_done_o`, `ready_o` and `fault_o` after edge E+2.
- R6: The interlock code {MSB,LSB} on `host_pwr_code_i` grants a budget: 00 grants 3 W, 01 grants 6 W, 10 grants 9 W and 11 grants 12 W. Suppose a power-up is requested, or has completed, while the granted budget is below MOD_PWR_W. Then `fault_o` rises and power-up does not complete. The fault remains until low power or reset is requested.
- R7: `los_o` is the OR of the four synchronised bits of `lane_los_i`.
- R8: `glb_alarm_n_o` is 0 when any synchronised bit of `alarm_bits_i` is 1 or when `fault_o` is 1. Otherwise it is 1.
- R9: `down_txoff_o` is 1 when the synchronised `host_txoff_i` is 1 (1 = disabled) or when `ready_o` is 0.
- R10: `down_lowpwr_o` is 0 only while power-up is waiting, complete or ready. `down_rst_n_o` equals the AND of the synchronised `host_rst_n_i` and `host_icrst_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_txoff_i | input | 1 | Host transmitter disable, 1 = disabled |
| host_lowpwr_i | input | 1 | Host low-power request, 1 = low power |
| host_rst_n_i | input | 1 | Host module reset, 0 = reset |
| host_icrst_n_i | input | 1 | Host transceiver IC reset, 0 = reset |
| host_addr_i | input | ADDR_W | Management port address |
| host_pwr_code_i | input | 2 | Power interlock code {MSB,LSB} |
| lane_los_i | input | LANES | Per-lane loss of signal from the module |
| alarm_bits_i | input | ALARM_W | Alarm register bits |
| pwr_done_o | output | 1 | High-power-up complete |
| ready_o | output | 1 | Module ready |
| fault_o | output | 1 | Fault detected |
| los_o | output | 1 | Loss of signal on any lane |
| glb_alarm_n_o | output | 1 | Global alarm, 0 = alarm |
| port_addr_o | output | ADDR_W | Synchronised port address |
| down_txoff_o | output | 1 | Downstream transmitter disable |
| down_lowpwr_o | output | 1 | Downstream low-power mode |
| down_rst_n_o | output | 1 | Downstream reset, 0 = reset |

## Verification
The power sequencer is tested with directed patterns, each aimed at one distinction:
- A clean power-up separates the exact cycles on which power-complete and ready rise.
- A low-power request and a module reset, each applied after ready, show that both clear the state.
- A refused interlock code, followed by a legal one, shows that the fault latches rather than tracking the code.
- A budget drop after ready shows that a fault can also arise after power-up has completed.

The pass-through paths are then driven with random lane loss-of-signal, alarm, address and transmitter-off values while the module is ready. The expected outputs lag the driven inputs by two cycles. This exposes any missing or extra synchroniser stage, as well as a wrong OR reduction.

// File: rtl/modpin_pkg.sv
package modpin_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_WAIT  = 3'd1,
        SEQ_DONE  = 3'd2,
        SEQ_READY = 3'd3,
        SEQ_FAULT = 3'd4
    } seq_state_t;

    localparam int BUDGET_W = 4;

    // Interlock code {MSB,LSB} to granted watts: 00->3, 01->6, 10->9, 11->12
    function automatic logic [BUDGET_W-1:0] budget_watts(input logic [1:0] code);
        return BUDGET_W'(({2'b00, code} + 4'd1) * 4'd3);
    endfunction

endpackage

// File: rtl/modpin_sync.sv
module modpin_sync #(
    parameter int          WIDTH = 1,
    parameter logic [63:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL[WIDTH-1:0];
            sync_q <= RST_VAL[WIDTH-1:0];
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/modpin_seq.sv
module modpin_seq
    import modpin_pkg::*;
#(
    parameter int PWRUP_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic       lowpwr_i,
    input  logic       budget_ok_i,
    output seq_state_t state_o
);
    localparam int CNT_W = $clog2(PWRUP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWRUP_CYC - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hp_req;

    assign hp_req = run_i && !lowpwr_i;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!hp_req) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
        end else if (!budget_ok_i) begin
            state_d = SEQ_FAULT;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    state_d = SEQ_WAIT;
                    cnt_d   = '0;
                end
                SEQ_WAIT: begin
                    if (cnt_q == CNT_LAST) state_d = SEQ_DONE;
                    else                   cnt_d   = cnt_q + 1'b1;
                end
                SEQ_DONE:  state_d = SEQ_READY;
                SEQ_READY: state_d = SEQ_READY;
                SEQ_FAULT: state_d = SEQ_FAULT;
                default:   state_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/modpin_ctrl.sv
module modpin_ctrl
    import modpin_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int LANES     = 4,
    parameter int ALARM_W   = 8,
    parameter int PWRUP_CYC = 16,
    parameter int MOD_PWR_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_txoff_i,
    input  logic               host_lowpwr_i,
    input  logic               host_rst_n_i,
    input  logic               host_icrst_n_i,
    input  logic [ADDR_W-1:0]  host_addr_i,
    input  logic [1:0]         host_pwr_code_i,
    input  logic [LANES-1:0]   lane_los_i,
    input  logic [ALARM_W-1:0] alarm_bits_i,
    output logic               pwr_done_o,
    output logic               ready_o,
    output logic               fault_o,
    output logic               los_o,
    output logic               glb_alarm_n_o,
    output logic [ADDR_W-1:0]  port_addr_o,
    output logic               down_txoff_o,
    output logic               down_lowpwr_o,
    output logic               down_rst_n_o
);
    localparam int CTL_W = 4;
    localparam logic [BUDGET_W-1:0] NEED_W = BUDGET_W'(MOD_PWR_W);

    // control bits: {icrst_n, rst_n, lowpwr, txoff}; safe values on reset
    logic [CTL_W-1:0]   ctl_s;
    logic [1:0]         code_s;
    logic [LANES-1:0]   los_s;
    logic [ALARM_W-1:0] alarm_s;
    seq_state_t         state;
    logic               budget_ok;

    modpin_sync #(.WIDTH(CTL_W), .RST_VAL(64'h3)) u_sync_ctl (
        .clk(clk), .rst(rst),
        .d_i({host_icrst_n_i, host_rst_n_i, host_lowpwr_i, host_txoff_i}),
        .q_o(ctl_s)
    );

    modpin_sync #(.WIDTH(2), .RST_VAL(64'h3)) u_sync_code (
        .clk(clk), .rst(rst), .d_i(host_pwr_code_i), .q_o(code_s)
    );

    modpin_sync #(.WIDTH(ADDR_W), .RST_VAL(64'h0)) u_sync_addr (
        .clk(clk), .rst(rst), .d_i(host_addr_i), .q_o(port_addr_o)
    );

    modpin_sync #(.WIDTH(LANES), .RST_VAL(64'h0)) u_sync_los (
        .clk(clk), .rst(rst), .d_i(lane_los_i), .q_o(los_s)
    );

    modpin_sync #(.WIDTH(ALARM_W), .RST_VAL(64'h0)) u_sync_alarm (
        .clk(clk), .rst(rst), .d_i(alarm_bits_i), .q_o(alarm_s)
    );

    assign budget_ok = budget_watts(code_s) >= NEED_W;

    modpin_seq #(.PWRUP_CYC(PWRUP_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .run_i      (ctl_s[2]),
        .lowpwr_i   (ctl_s[1]),
        .budget_ok_i(budget_ok),
        .state_o    (state)
    );

    assign pwr_done_o    = (state == SEQ_DONE) || (state == SEQ_READY);
    assign ready_o       = (state == SEQ_READY);
    assign fault_o       = (state == SEQ_FAULT);
    assign los_o         = |los_s;
    assign glb_alarm_n_o = !((|alarm_s) || fault_o);
    assign down_txoff_o  = ctl_s[0] || !ready_o;
    assign down_lowpwr_o = !((state == SEQ_WAIT) || pwr_done_o);
    assign down_rst_n_o  = ctl_s[3] && ctl_s[2];
endmodule

// File: rtl/modpin_ctrl_chk.sv
module modpin_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic pwr_done_o,
    input logic ready_o,
    input logic fault_o,
    input logic glb_alarm_n_o,
    input logic down_txoff_o,
    input logic down_lowpwr_o
);
    AST_READY_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> pwr_done_o); // R4
    AST_READY_AFTER_PWR: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(pwr_done_o)); // R4
    AST_FAULT_NO_PWR: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !pwr_done_o); // R6
    AST_FAULT_ALARM: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !glb_alarm_n_o); // R8
    AST_TX_OFF_UNREADY: assert property (@(posedge clk) disable iff (rst)
        !ready_o |-> down_txoff_o); // R9
    AST_LOWPWR_WHEN_FAULT: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> down_lowpwr_o); // R10
endmodule

bind modpin_ctrl modpin_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .pwr_done_o(pwr_done_o), .ready_o(ready_o),
    .fault_o(fault_o), .glb_alarm_n_o(glb_alarm_n_o),
    .down_txoff_o(down_txoff_o), .down_lowpwr_o(down_lowpwr_o)
);

// File: tb/tb_modpin_ctrl.sv
module tb_modpin_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 3, LANES = 4, ALARM_W = 8, PWRUP_CYC = 5, MOD_PWR_W = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic txoff, lowpwr, rst_n, icrst_n;
    logic [ADDR_W-1:0] addr;
    logic [1:0] code;
    logic [LANES-1:0] los;
    logic [ALARM_W-1:0] alarm;
    logic pwr_done, ready, fault, los_o, galrm_n, txo, lpo, drst_n;
    logic [ADDR_W-1:0] paddr;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modpin_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .ALARM_W(ALARM_W),
                  .PWRUP_CYC(PWRUP_CYC), .MOD_PWR_W(MOD_PWR_W)) dut (
        .clk(clk), .rst(rst), .host_txoff_i(txoff), .host_lowpwr_i(lowpwr),
        .host_rst_n_i(rst_n), .host_icrst_n_i(icrst_n), .host_addr_i(addr),
        .host_pwr_code_i(code), .lane_los_i(los), .alarm_bits_i(alarm),
        .pwr_done_o(pwr_done), .ready_o(ready), .fault_o(fault), .los_o(los_o),
        .glb_alarm_n_o(galrm_n), .port_addr_o(paddr), .down_txoff_o(txo),
        .down_lowpwr_o(lpo), .down_rst_n_o(drst_n)
    );

    function automatic int grant_w(input logic [1:0] c);
        case (c)
            2'b00: return 3;
            2'b01: return 6;
            2'b10: return 9;
            default: return 12;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] a1, a2;
        logic [LANES-1:0]  l1, l2;
        logic [ALARM_W-1:0] m1, m2;
        logic t1, t2;
        void'($urandom(32'd1234));
        txoff = 1; lowpwr = 1; rst_n = 1; icrst_n = 1;
        addr = 0; code = 2'b11; los = 0; alarm = 0;
        tick(3);
        // R2 reset state
        chk("R2 pwr_done", pwr_done, 0); chk("R2 ready", ready, 0);
        chk("R2 fault", fault, 0); chk("R2 los", los_o, 0);
        chk("R2 glb_alarm_n", galrm_n, 1); chk("R2 txoff", txo, 1);
        chk("R2 lowpwr", lpo, 1); chk("R2 rst_n", drst_n, 0);
        rst = 0;
        tick(3);
        chk("R10 down_rst_n released", drst_n, 1);
        chk("R10 lowpwr idle", lpo, 1);

        // R3/R4 power-up timing
        lowpwr = 0;
        tick(PWRUP_CYC + 2);
        chk("R3 pwr_done not early", pwr_done, 0);
        chk("R10 lowpwr during wait", lpo, 0);
        tick(1);
        chk("R3 pwr_done rises", pwr_done, 1);
        chk("R4 ready lags", ready, 0);
        tick(1);
        chk("R4 ready rises", ready, 1);
        chk("R9 txoff still requested", txo, 1);
        txoff = 0;
        tick(2);
        chk("R9 tx enabled", txo, 0);

        // R10 ic reset only affects downstream reset
        icrst_n = 0;
        tick(2);
        chk("R10 ic reset", drst_n, 0);
        chk("R10 ic reset keeps ready", ready, 1);
        icrst_n = 1;
        tick(2);

        // R5 low power clears
        lowpwr = 1;
        tick(2);
        chk("R5 not yet cleared", ready, 1);
        tick(1);
        chk("R5 lowpwr clears pwr_done", pwr_done, 0);
        chk("R5 lowpwr clears ready", ready, 0);
        chk("R9 tx off when unready", txo, 1);
        lowpwr = 0;
        tick(PWRUP_CYC + 4);
        chk("R3 second power-up", ready, 1);
        // R5 module reset clears
        rst_n = 0;
        tick(3);
        chk("R5 reset clears pwr_done", pwr_done, 0);
        chk("R5 reset clears ready", ready, 0);
        chk("R10 reset drives down_rst_n", drst_n, 0);
        rst_n = 1;

        // R6 interlock refusal: code 00 gives 3 W < 4 W need
        code = 2'b00;
        tick(3);
        chk("R6 fault on 3W", fault, (grant_w(2'b00) < MOD_PWR_W) ? 1 : 0);
        chk("R8 alarm on fault", galrm_n, 0);
        tick(PWRUP_CYC + 4);
        chk("R6 no power-up", pwr_done, 0);
        code = 2'b01;
        tick(PWRUP_CYC + 4);
        chk("R6 fault latched", fault, 1);
        lowpwr = 1;
        tick(3);
        chk("R5 lowpwr clears fault", fault, 0);
        chk("R8 alarm cleared", galrm_n, 1);
        lowpwr = 0;
        tick(PWRUP_CYC + 4);
        chk("R6 6W grants power", ready, (grant_w(2'b01) >= MOD_PWR_W) ? 1 : 0);
        code = 2'b00;
        tick(3);
        chk("R6 budget drop faults", fault, 1);
        chk("R6 budget drop clears ready", ready, 0);
        lowpwr = 1; code = 2'b10;
        tick(3);
        lowpwr = 0;
        tick(PWRUP_CYC + 4);
        chk("R6 9W ready", ready, 1);

        // R1/R7/R8/R9 random pass-through with two-cycle lag
        a1 = addr; a2 = addr; l1 = los; l2 = los; m1 = alarm; m2 = alarm;
        t1 = txoff; t2 = txoff;
        for (int i = 0; i < 300; i++) begin
            a2 = a1; l2 = l1; m2 = m1; t2 = t1;
            a1 = addr; l1 = los; m1 = alarm; t1 = txoff;
            if (i >= 2) begin
                chk("R1 port address lag", paddr, a2);
                chk("R7 los OR", los_o, |l2);
                chk("R8 alarm OR", galrm_n, !(|m2));
                chk("R9 txoff pass", txo, t2);
            end
            addr  = ADDR_W'($urandom);
            los   = ($urandom % 3 == 0) ? LANES'(1 << ($urandom % LANES)) : '0;
            alarm = ($urandom % 4 == 0) ? ALARM_W'($urandom) : '0;
            txoff = 1'($urandom);
            tick(1);
        end
        chk("R4 still ready", ready, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule